// File: doc/BRIEF.md
# Workload-Based Temperature Predictor

This block estimates how hot a processing element is becoming without a thermal sensor. Every cycle it counts workload events: task grants issued to each of the four neighbouring elements, and packets accepted from the element's own main input stream. A tracker register adds up these events over a fixed prediction window. A watchdog timer measures out that window.

When the watchdog expires, the estimate is updated and both the timer and the tracker start again. A busy window raises the predicted temperature in proportion to the number of events, up to a ceiling. An idle window lets it cool by a fixed step, down to an ambient floor. Neighbouring agents and the local controller compare the predicted value with their thresholds to decide whether to accept or migrate work.

Top module: `wtp_predictor`

## Requirements
- R1: While rst_ni is low, temp_o equals AMBIENT (default 25), the tracker is empty and the watchdog is at the start of a fresh window.
- R2: The workload count of a cycle is the number of bits set in nbr_grant_i plus one if main_accept_i is high. Events that occur together in one cycle each add one to the tracker.
- R3: The prediction window is WINDOW cycles long (default 16), counted from reset release. temp_o changes only on the clock edge that ends a window and holds steady at every other edge.
- R4: At the end of a window with N events in total, counting the final cycle, temp_o rises by N*STEP_UP (default STEP_UP is 1).
- R5: temp_o saturates at TEMP_MAX (default 120) and does not wrap. It always stays within AMBIENT..TEMP_MAX.
- R6: At the end of a window with no events, temp_o falls by STEP_DN (default 2) but never goes below AMBIENT.
- R7: At every window end the watchdog reloads its timeout constant and the tracker clears, so events never carry into the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nbr_grant_i | input | 4 | Grant issued to each of the four neighbours this cycle |
| main_accept_i | input | 1 | Packet accepted from the main input stream this cycle |
| temp_o | output | TEMP_W (8) | Predicted temperature |

## Verification
On every cycle the assertions check the following:
- the watchdog ticks down, and reloads at expiry;
- the tracker grows by exactly that cycle's event count;
- the estimate is steady away from a window end;
- the estimate moves in the right direction at a window end;
- the estimate stays between floor and ceiling.

The exact magnitudes need the bench's scenarios: the rise for a given mix of simultaneous grants and accepts, clipping at the ceiling, and the cooling step against the floor. The bench also shows that a reset in the middle of a window discards its events and realigns the window.

// File: rtl/wtp_pkg.sv
package wtp_pkg;
  localparam int unsigned NBR = 4;

  function automatic int unsigned event_count(input logic [NBR-1:0] grant,
                                              input logic           accept);
    return int'($countones(grant)) + int'(accept);
  endfunction
endpackage

// File: rtl/wtp_tracker.sv
module wtp_tracker #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned EV_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EV_W-1:0]  ev_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] trk_o,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] trk_q;

  // total includes this cycle so the closing cycle of a window is counted
  assign total_o = trk_q + CNT_W'(ev_i);
  assign trk_o   = trk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       trk_q <= '0;
    else if (expire_i) trk_q <= '0;
    else               trk_q <= total_o;
  end
endmodule

// File: rtl/wtp_window_timer.sv
module wtp_window_timer #(
  parameter int unsigned WINDOW = 16,
  parameter int unsigned WD_W   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [WD_W-1:0] wd_o,
  output logic            expire_o
);
  localparam logic [WD_W-1:0] RELOAD = WD_W'(WINDOW - 1);

  logic [WD_W-1:0] wd_q;

  assign expire_o = (wd_q == '0);
  assign wd_o     = wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wd_q <= RELOAD;
    else if (expire_o) wd_q <= RELOAD;
    else               wd_q <= wd_q - 1'b1;
  end
endmodule

// File: rtl/wtp_estimator.sv
module wtp_estimator #(
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned AMBIENT  = 25,
  parameter int unsigned TEMP_MAX = 120,
  parameter int unsigned STEP_UP  = 1,
  parameter int unsigned STEP_DN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  total_i,
  output logic [TEMP_W-1:0] temp_o
);
  localparam int unsigned SUM_W = TEMP_W + CNT_W + 8;

  logic [TEMP_W-1:0] temp_q, temp_d;
  logic [SUM_W-1:0]  heat;

  always_comb begin
    heat   = SUM_W'(temp_q) + SUM_W'(total_i) * SUM_W'(STEP_UP);
    temp_d = temp_q;
    if (expire_i) begin
      if (total_i != '0)
        temp_d = (heat > SUM_W'(TEMP_MAX)) ? TEMP_W'(TEMP_MAX) : TEMP_W'(heat);
      else if (SUM_W'(temp_q) >= SUM_W'(AMBIENT) + SUM_W'(STEP_DN))
        temp_d = temp_q - TEMP_W'(STEP_DN);
      else
        temp_d = TEMP_W'(AMBIENT);
    end
  end

  assign temp_o = temp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) temp_q <= TEMP_W'(AMBIENT);
    else         temp_q <= temp_d;
  end
endmodule

// File: rtl/wtp_predictor.sv
module wtp_predictor
  import wtp_pkg::*;
#(
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned WINDOW   = 16,
  parameter int unsigned AMBIENT  = 25,
  parameter int unsigned TEMP_MAX = 120,
  parameter int unsigned STEP_UP  = 1,
  parameter int unsigned STEP_DN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBR-1:0]    nbr_grant_i,
  input  logic              main_accept_i,
  output logic [TEMP_W-1:0] temp_o
);
  localparam int unsigned EV_MAX = NBR + 1;
  localparam int unsigned EV_W   = $clog2(EV_MAX + 1);
  localparam int unsigned CNT_W  = $clog2(EV_MAX * WINDOW + 1);
  localparam int unsigned WD_W   = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [EV_W-1:0]  ev_cnt;
  logic [CNT_W-1:0] trk_q, trk_total;
  logic [WD_W-1:0]  wd_cnt;
  logic             expire;

  assign ev_cnt = EV_W'(event_count(nbr_grant_i, main_accept_i));

  wtp_window_timer #(.WINDOW(WINDOW), .WD_W(WD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wd_o     (wd_cnt),
    .expire_o (expire)
  );

  wtp_tracker #(.CNT_W(CNT_W), .EV_W(EV_W)) u_tracker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_cnt),
    .expire_i (expire),
    .trk_o    (trk_q),
    .total_o  (trk_total)
  );

  wtp_estimator #(
    .TEMP_W(TEMP_W), .CNT_W(CNT_W), .AMBIENT(AMBIENT),
    .TEMP_MAX(TEMP_MAX), .STEP_UP(STEP_UP), .STEP_DN(STEP_DN)
  ) u_est (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .total_i  (trk_total),
    .temp_o   (temp_o)
  );
endmodule

// File: rtl/wtp_predictor_chk.sv
module wtp_predictor_chk #(
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned WINDOW   = 16,
  parameter int unsigned AMBIENT  = 25,
  parameter int unsigned TEMP_MAX = 120,
  parameter int unsigned STEP_DN  = 2,
  parameter int unsigned EV_W     = 3,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned WD_W     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TEMP_W-1:0] temp_i,
  input logic              expire_i,
  input logic [WD_W-1:0]   wd_i,
  input logic [CNT_W-1:0]  trk_i,
  input logic [CNT_W-1:0]  total_i,
  input logic [EV_W-1:0]   ev_i
);
  assert_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= TEMP_W'(AMBIENT)) && (temp_i <= TEMP_W'(TEMP_MAX)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> $stable(temp_i));

  assert_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> wd_i == $past(wd_i) - 1'b1);

  assert_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> trk_i == $past(trk_i) + CNT_W'($past(ev_i)));

  assert_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && total_i != '0) |=>
      (temp_i == TEMP_W'(TEMP_MAX) || temp_i > $past(temp_i)));

  assert_cool_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && total_i == '0) |=>
      (temp_i == TEMP_W'(AMBIENT) || temp_i == $past(temp_i) - TEMP_W'(STEP_DN)));

  assert_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (wd_i == WD_W'(WINDOW - 1)) && (trk_i == '0));
endmodule

bind wtp_predictor wtp_predictor_chk #(
  .TEMP_W(TEMP_W), .WINDOW(WINDOW), .AMBIENT(AMBIENT), .TEMP_MAX(TEMP_MAX),
  .STEP_DN(STEP_DN), .EV_W(EV_W), .CNT_W(CNT_W), .WD_W(WD_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .temp_i   (temp_o),
  .expire_i (expire),
  .wd_i     (wd_cnt),
  .trk_i    (trk_q),
  .total_i  (trk_total),
  .ev_i     (ev_cnt)
);

// File: tb/wtp_predictor_tb.sv
module wtp_predictor_tb;
  localparam int CLK_P  = 10;
  localparam int WINDOW = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] grant = '0;
  logic       accept = 1'b0;
  logic [7:0] temp;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wtp_predictor u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .nbr_grant_i   (grant),
    .main_accept_i (accept),
    .temp_o        (temp)
  );

  // {grant[3:0], accept, expected temp after one full window}
  localparam logic [12:0] VEC [0:9] = '{
    {4'b0000, 1'b0, 8'd25},   // R6 floor
    {4'b0001, 1'b0, 8'd41},   // R4
    {4'b0000, 1'b0, 8'd39},   // R6
    {4'b0011, 1'b1, 8'd87},   // R2 three events per cycle
    {4'b0000, 1'b0, 8'd85},
    {4'b1111, 1'b1, 8'd120},  // R5 saturate
    {4'b0000, 1'b0, 8'd118},
    {4'b1000, 1'b1, 8'd120},  // R5
    {4'b0100, 1'b0, 8'd120},  // R5
    {4'b0000, 1'b0, 8'd118}
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (temp !== exp) begin
      n_bad++;
      $display("FAIL %s: temp_o=%0d expected=%0d", req, temp, exp);
    end
  endtask

  // entered and left at a falling edge; covers n rising edges
  task automatic run(input logic [3:0] g, input logic a, input int n);
    grant  = g;
    accept = a;
    repeat (n) @(negedge clk);
    grant  = '0;
    accept = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1", 8'd25);
    rst_ni = 1'b1;
    for (int i = 0; i < 10; i++) begin
      run(VEC[i][12:9], VEC[i][8], WINDOW);
      check("R4/R5/R6", VEC[i][7:0]);
    end
    // R3: single event early in window, no change mid-window
    run(4'b0100, 1'b0, 1);
    run(4'b0000, 1'b0, 7);
    check("R3", 8'd118);
    run(4'b0000, 1'b0, 7);
    check("R3", 8'd118);
    run(4'b0000, 1'b0, 1);
    check("R4", 8'd119);
    // R7: events do not carry into the following window
    run(4'b0000, 1'b0, WINDOW);
    check("R7", 8'd117);
    // R1: reset in mid-window discards events and realigns the window
    run(4'b1111, 1'b1, 5);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1", 8'd25);
    rst_ni = 1'b1;
    run(4'b0000, 1'b0, WINDOW);
    check("R1", 8'd25);
    run(4'b0001, 1'b0, WINDOW - 1);
    check("R3", 8'd25);
    run(4'b0000, 1'b0, 1);
    check("R2", 8'd40);
    // R2: all five event sources on the closing cycle only
    run(4'b0000, 1'b0, WINDOW - 1);
    run(4'b1111, 1'b1, 1);
    check("R2", 8'd45);
    done = 1'b1;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: bench did not complete");
    end
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000 + CLK_P);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule